// File: doc/BRIEF.md
# Flash ready and error poller

This block decides, after a program or erase has been started on a serial NOR flash, when the device can take a new command and whether the operation failed. It sits above a byte-level command engine and talks to it through a request/response interface. For each step it drives an opcode together with an address byte count, a dummy count and a data byte count. It then takes the returned data bytes and waits for a done pulse from the engine. Serial pin timing and the flash array itself are handled elsewhere.

A requester pulses `start_i`. The block reads the ordinary status register and then the flag register, and repeats this pair for as long as either register reports busy. It stops when both registers report ready or when a programmable poll limit runs out. If the flag register reports a failed erase or program, the block clears the flags and then sends write-disable, because the write-enable latch stays set after such a failure. It then ends with error flags instead of a ready result. All results are registered and held until the next start.

Top module: `flash_rdy_poll`

## Requirements
- R1: A `start_i` pulse while idle starts a run. The first command is a status read (opcode 0x05), and the second is a flag read (opcode 0x70). Reads always alternate in that order.
- R2: The status read uses 0 address bytes, 0 dummy and 1 data byte. With `octal_dtr_i` low, the flag read uses the same 0/0/1 shape. With `octal_dtr_i` high, the flag read uses `cfg_addr_bytes_i` address bytes, `cfg_dummy_i` dummy cycles and 2 data bytes. Only the first byte returned on `cmd_rbyte_i` is used, and any later byte of the same command is ignored.
- R3: When status bit 0 (write in progress) is 0 and flag bit 7 (ready) is 1, and neither failure bit is set, the run ends with `ready_o`=1 and all other result flags at 0.
- R4: If status bit 0 is 1 or flag bit 7 is 0, and no failure bit is set, the status/flag read pair is issued again.
- R5: Flag bit 5 set gives `erase_err_o`. Otherwise, flag bit 4 set gives `prog_err_o`. A failure bit takes precedence over a busy indication.
- R6: On a failure, the block issues a flag clear (opcode 0x50) and then write-disable (opcode 0x04). Both have 0 address bytes, 0 dummy and 0 data bytes. Only then is `done_o` raised.
- R7: Flag bit 1 (protection) raises `prot_err_o` only together with an erase or program failure. On its own it has no effect on the result.
- R8: After max(`poll_limit_i`,1) read pairs that all reported busy, the run ends with `timeout_o`=1 and `ready_o`=0. A pair that reports ready at exactly the limit ends with `ready_o`=1.
- R9: `done_o` and the result flags hold their values until the next accepted start, which clears them at the following clock edge. A `start_i` received during a run is ignored.
- R10: `cmd_req_o` is a single-cycle pulse. The next command is requested only after `cmd_done_i` for the previous one.
- R11: After reset, `done_o`, `cmd_req_o` and all result flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a poll run (accepted when idle) |
| poll_limit_i | input | CW | Maximum number of busy read pairs |
| octal_dtr_i | input | 1 | Register accesses use octal double data rate |
| cfg_addr_bytes_i | input | 3 | Flag-read address bytes in octal DTR mode |
| cfg_dummy_i | input | DW | Flag-read dummy cycles in octal DTR mode |
| cmd_req_o | output | 1 | Command request pulse to the engine |
| cmd_op_o | output | 8 | Command opcode |
| cmd_addr_bytes_o | output | 3 | Address byte count |
| cmd_dummy_o | output | DW | Dummy cycle count |
| cmd_len_o | output | 2 | Data byte count |
| cmd_rvalid_i | input | 1 | Read byte valid from the engine |
| cmd_rbyte_i | input | 8 | Read byte from the engine |
| cmd_done_i | input | 1 | Command complete pulse |
| done_o | output | 1 | Run finished, held until next start |
| ready_o | output | 1 | Device ready |
| timeout_o | output | 1 | Poll limit exhausted |
| erase_err_o | output | 1 | Erase failure |
| prog_err_o | output | 1 | Program failure |
| prot_err_o | output | 1 | Protection violation accompanying a failure |

## Verification
A wrong sequencer state shows up right away on the command port. A bad opcode, a changed byte/dummy shape or a missing step appears on the next `cmd_req_o` pulse. An extra request that arrives before `cmd_done_i` is also visible there. A wrongly captured byte or a mis-classified flag shows up within one run: the command count is off (a recovery pair is missing or a poll is lost) or the result flags are wrong when `done_o` rises. A corrupted poll counter changes the number of read pairs before timeout, so a run with a known number of busy replies exposes it.

// File: rtl/flash_rdy_pkg.sv
package flash_rdy_pkg;
  localparam logic [7:0] OP_RDSR    = 8'h05;
  localparam logic [7:0] OP_RDFLAG  = 8'h70;
  localparam logic [7:0] OP_CLRFLAG = 8'h50;
  localparam logic [7:0] OP_WRDI    = 8'h04;

  localparam int FL_RDY  = 7;
  localparam int FL_ERS  = 5;
  localparam int FL_PGM  = 4;
  localparam int FL_PROT = 1;
  localparam int SR_WIP  = 0;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDSR, ST_RDFL, ST_CLR, ST_WRDI
  } step_e;

  typedef struct packed {
    logic rdy;
    logic ers;
    logic pgm;
    logic prot;
    logic fail;
  } flag_info_t;
endpackage

// File: rtl/frp_flag_decode.sv
module frp_flag_decode
  import flash_rdy_pkg::*;
(
  input  logic [7:0]  flag_i,
  output flag_info_t  info_o
);
  logic unused_bits;
  assign unused_bits = ^{flag_i[6], flag_i[3:2], flag_i[0]};

  always_comb begin
    info_o.rdy  = flag_i[FL_RDY];
    info_o.ers  = flag_i[FL_ERS];
    info_o.pgm  = flag_i[FL_PGM] & ~flag_i[FL_ERS];  // erase wins
    info_o.prot = flag_i[FL_PROT];
    info_o.fail = flag_i[FL_ERS] | flag_i[FL_PGM];
  end
endmodule

// File: rtl/frp_poll_cnt.sv
module frp_poll_cnt #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          inc_i,
  input  logic [CW-1:0] limit_i,
  output logic          hit_o
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   nxt;

  assign nxt   = {1'b0, cnt_q} + (CW+1)'(1);
  assign hit_o = nxt >= {1'b0, limit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= nxt[CW-1:0];
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |-> (cnt_q < limit_i)); // R8
endmodule

// File: rtl/flash_rdy_poll.sv
module flash_rdy_poll
  import flash_rdy_pkg::*;
#(
  parameter int CW = 8,
  parameter int DW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] poll_limit_i,
  input  logic          octal_dtr_i,
  input  logic [2:0]    cfg_addr_bytes_i,
  input  logic [DW-1:0] cfg_dummy_i,
  output logic          cmd_req_o,
  output logic [7:0]    cmd_op_o,
  output logic [2:0]    cmd_addr_bytes_o,
  output logic [DW-1:0] cmd_dummy_o,
  output logic [1:0]    cmd_len_o,
  input  logic          cmd_rvalid_i,
  input  logic [7:0]    cmd_rbyte_i,
  input  logic          cmd_done_i,
  output logic          done_o,
  output logic          ready_o,
  output logic          timeout_o,
  output logic          erase_err_o,
  output logic          prog_err_o,
  output logic          prot_err_o
);
  step_e      state_q, state_d;
  logic       req_q;
  logic       got_q;
  logic [7:0] rbyte_q;
  logic       wip_q;
  logic       pend_ers_q, pend_pgm_q, pend_prot_q;
  logic       inc, fin, fin_rdy, fin_tmo, lim_hit, accept;
  flag_info_t flag;

  frp_flag_decode u_dec (
    .flag_i (rbyte_q),
    .info_o (flag)
  );

  frp_poll_cnt #(.CW(CW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (state_q == ST_IDLE),
    .inc_i   (inc),
    .limit_i (poll_limit_i),
    .hit_o   (lim_hit)
  );

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    inc     = 1'b0;
    fin     = 1'b0;
    fin_rdy = 1'b0;
    fin_tmo = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_RDSR;
      ST_RDSR: if (cmd_done_i) state_d = ST_RDFL;
      ST_RDFL: if (cmd_done_i) begin
        if (flag.fail) begin
          state_d = ST_CLR;
        end else if (!wip_q && flag.rdy) begin
          state_d = ST_IDLE;
          fin     = 1'b1;
          fin_rdy = 1'b1;
        end else if (lim_hit) begin
          state_d = ST_IDLE;
          fin     = 1'b1;
          fin_tmo = 1'b1;
        end else begin
          state_d = ST_RDSR;
          inc     = 1'b1;
        end
      end
      ST_CLR:  if (cmd_done_i) state_d = ST_WRDI;
      ST_WRDI: if (cmd_done_i) begin
        state_d = ST_IDLE;
        fin     = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // command shape per step
  always_comb begin
    cmd_op_o         = 8'h00;
    cmd_addr_bytes_o = 3'd0;
    cmd_dummy_o      = '0;
    cmd_len_o        = 2'd0;
    unique case (state_q)
      ST_RDSR: begin
        cmd_op_o  = OP_RDSR;
        cmd_len_o = 2'd1;
      end
      ST_RDFL: begin
        cmd_op_o = OP_RDFLAG;
        if (octal_dtr_i) begin
          cmd_addr_bytes_o = cfg_addr_bytes_i;
          cmd_dummy_o      = cfg_dummy_i;
          cmd_len_o        = 2'd2;
        end else begin
          cmd_len_o = 2'd1;
        end
      end
      ST_CLR:  cmd_op_o = OP_CLRFLAG;
      ST_WRDI: cmd_op_o = OP_WRDI;
      default: cmd_op_o = 8'h00;
    endcase
  end

  assign cmd_req_o = req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      req_q       <= 1'b0;
      got_q       <= 1'b0;
      rbyte_q     <= 8'h00;
      wip_q       <= 1'b0;
      pend_ers_q  <= 1'b0;
      pend_pgm_q  <= 1'b0;
      pend_prot_q <= 1'b0;
      done_o      <= 1'b0;
      ready_o     <= 1'b0;
      timeout_o   <= 1'b0;
      erase_err_o <= 1'b0;
      prog_err_o  <= 1'b0;
      prot_err_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= (state_d != state_q) && (state_d != ST_IDLE);

      // keep only the first byte of each command
      if (req_q) got_q <= 1'b0;
      else if (cmd_rvalid_i && !got_q) begin
        got_q   <= 1'b1;
        rbyte_q <= cmd_rbyte_i;
      end

      if (state_q == ST_RDSR && cmd_done_i) wip_q <= rbyte_q[SR_WIP];

      if (accept) begin
        pend_ers_q  <= 1'b0;
        pend_pgm_q  <= 1'b0;
        pend_prot_q <= 1'b0;
      end else if (state_q == ST_RDFL && cmd_done_i && flag.fail) begin
        pend_ers_q  <= flag.ers;
        pend_pgm_q  <= flag.pgm;
        pend_prot_q <= flag.prot;
      end

      if (accept) begin
        done_o      <= 1'b0;
        ready_o     <= 1'b0;
        timeout_o   <= 1'b0;
        erase_err_o <= 1'b0;
        prog_err_o  <= 1'b0;
        prot_err_o  <= 1'b0;
      end else if (fin) begin
        done_o      <= 1'b1;
        ready_o     <= fin_rdy;
        timeout_o   <= fin_tmo;
        erase_err_o <= pend_ers_q;
        prog_err_o  <= pend_pgm_q;
        prot_err_o  <= pend_prot_q;
      end
    end
  end

  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_req_o |=> !cmd_req_o); // R10
  AST_REQ_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && !cmd_done_i) |=> !cmd_req_o); // R10
  AST_CLR_THEN_WRDI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CLR && cmd_done_i) |=> (cmd_req_o && cmd_op_o == OP_WRDI)); // R6
  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !(erase_err_o && prog_err_o)); // R5
  AST_READY_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !(erase_err_o || prog_err_o || timeout_o || prot_err_o)); // R3
  AST_PROT_WITH_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prot_err_o |-> (erase_err_o || prog_err_o)); // R7
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable({ready_o, timeout_o, erase_err_o,
                                                  prog_err_o, prot_err_o}))); // R9
  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> (!done_o && cmd_req_o && cmd_op_o == OP_RDSR)); // R1
endmodule

// File: tb/sim_flash_rdy_poll.sv
module sim_flash_rdy_poll;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 8;
  localparam int DW = 5;

  typedef struct packed {
    logic [3:0] busy_n;   // number of busy pairs before the final reply
    logic       busy_sr;  // busy shown by status (1) or by flag register (0)
    logic [7:0] fsr;      // final flag byte
    logic       oct;
    logic [7:0] lim;
    logic [4:0] exp;      // {ready, timeout, erase, prog, prot}
    logic [4:0] ncmd;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd0, 1'b0, 8'h80, 1'b0, 8'd4, 5'b10000, 5'd2},  // R3 immediate ready
    '{4'd2, 1'b1, 8'h80, 1'b0, 8'd4, 5'b10000, 5'd6},  // R4 status busy
    '{4'd2, 1'b0, 8'h80, 1'b0, 8'd4, 5'b10000, 5'd6},  // R4 flag busy
    '{4'd5, 1'b1, 8'h80, 1'b0, 8'd3, 5'b01000, 5'd6},  // R8 timeout
    '{4'd0, 1'b0, 8'hA0, 1'b0, 8'd4, 5'b00100, 5'd4},  // R5 erase
    '{4'd0, 1'b0, 8'h90, 1'b0, 8'd4, 5'b00010, 5'd4},  // R5 program
    '{4'd0, 1'b0, 8'hB2, 1'b0, 8'd4, 5'b00101, 5'd4},  // R5 R7 erase wins + prot
    '{4'd0, 1'b0, 8'h92, 1'b0, 8'd4, 5'b00011, 5'd4},  // R7 program + prot
    '{4'd0, 1'b0, 8'h82, 1'b0, 8'd4, 5'b10000, 5'd2},  // R7 prot alone ignored
    '{4'd0, 1'b0, 8'h80, 1'b1, 8'd4, 5'b10000, 5'd2},  // R2 octal, 2nd byte ignored
    '{4'd0, 1'b0, 8'h20, 1'b0, 8'd4, 5'b00100, 5'd4},  // R5 failure beats busy
    '{4'd9, 1'b1, 8'h80, 1'b0, 8'd0, 5'b01000, 5'd2},  // R8 limit 0 acts as 1
    '{4'd2, 1'b1, 8'h80, 1'b0, 8'd3, 5'b10000, 5'd6},  // R8 ready at limit
    '{4'd1, 1'b0, 8'h80, 1'b1, 8'd2, 5'b10000, 5'd4}   // R2 R4 octal repeat
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] poll_limit_i = '0;
  logic          octal_dtr_i = 1'b0;
  logic [2:0]    cfg_addr_bytes_i = 3'd4;
  logic [DW-1:0] cfg_dummy_i = 5'd8;
  logic          cmd_req_o;
  logic [7:0]    cmd_op_o;
  logic [2:0]    cmd_addr_bytes_o;
  logic [DW-1:0] cmd_dummy_o;
  logic [1:0]    cmd_len_o;
  logic          cmd_rvalid_i = 1'b0;
  logic [7:0]    cmd_rbyte_i = 8'h00;
  logic          cmd_done_i = 1'b0;
  logic          done_o, ready_o, timeout_o, erase_err_o, prog_err_o, prot_err_o;

  flash_rdy_poll #(.CW(CW), .DW(DW)) u0 (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int   checks = 0;
  int   errors = 0;
  vec_t cur;
  int   pair_idx, n_cmds, fld_bad, viol, eng_dly;
  int   op_log [32];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // command engine model
  task automatic serve();
    logic [7:0] op;
    logic [7:0] first;
    int len;
    op  = cmd_op_o;
    len = int'(cmd_len_o);
    if (n_cmds < 32) op_log[n_cmds] = int'(op);
    n_cmds++;
    case (op)
      8'h05: if (cmd_addr_bytes_o != 0 || cmd_dummy_o != 0 || len != 1) fld_bad++;
      8'h70:
        if (cur.oct) begin
          if (cmd_addr_bytes_o != 3'd4 || cmd_dummy_o != 5'd8 || len != 2) fld_bad++;
        end else if (cmd_addr_bytes_o != 0 || cmd_dummy_o != 0 || len != 1) fld_bad++;
      8'h50, 8'h04: if (cmd_addr_bytes_o != 0 || cmd_dummy_o != 0 || len != 0) fld_bad++;
      default: fld_bad++;
    endcase
    first = 8'h00;
    if (op == 8'h05)
      first = (pair_idx < int'(cur.busy_n) && cur.busy_sr) ? 8'h03 : 8'h02;
    else if (op == 8'h70) begin
      first = (pair_idx < int'(cur.busy_n) && !cur.busy_sr) ? 8'h00 : cur.fsr;
      pair_idx++;
    end
    for (int d = 0; d < eng_dly; d++) begin
      @(negedge clk_i);
      if (cmd_req_o) viol++;
    end
    for (int b = 0; b < len; b++) begin
      cmd_rvalid_i = 1'b1;
      cmd_rbyte_i  = (b == 0) ? first : 8'h5A;
      @(negedge clk_i);
      if (cmd_req_o) viol++;
    end
    cmd_rvalid_i = 1'b0;
    cmd_done_i   = 1'b1;
  endtask

  initial begin
    forever begin
      @(negedge clk_i);
      cmd_done_i = 1'b0;
      if (cmd_req_o) serve();
    end
  end

  task automatic finish_all();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_all();
  end

  task automatic prep(input vec_t v);
    cur = v; pair_idx = 0; n_cmds = 0; fld_bad = 0; viol = 0;
    poll_limit_i = v.lim;
    octal_dtr_i  = v.oct;
  endtask

  task automatic wait_done();
    for (int g = 0; g < 20000 && !done_o; g++) @(negedge clk_i);
    chk(done_o, "R9", "done reached", int'(done_o), 1);
  endtask

  task automatic pulse_start();
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  function automatic logic [4:0] result();
    return {ready_o, timeout_o, erase_err_o, prog_err_o, prot_err_o};
  endfunction

  task automatic check_order(input vec_t v, input int idx);
    bit fail;
    int pairs;
    bit ok;
    fail  = v.exp[2] | v.exp[1];
    pairs = fail ? (int'(v.ncmd) - 2) / 2 : int'(v.ncmd) / 2;
    ok = 1'b1;
    for (int i = 0; i < int'(v.ncmd) && i < 32; i++) begin
      int e;
      if (i < 2*pairs) e = (i % 2 == 0) ? 8'h05 : 8'h70;
      else e = (i == 2*pairs) ? 8'h50 : 8'h04;
      if (op_log[i] != e) ok = 1'b0;
    end
    chk(ok, "R1/R4/R6", $sformatf("op order vec %0d", idx), 0, 0);
  endtask

  logic [4:0] held;

  initial begin
    eng_dly = 2;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    chk(!done_o && !cmd_req_o, "R11", "done/req after reset", int'({done_o, cmd_req_o}), 0);
    chk(result() == 5'b0, "R11", "flags after reset", int'(result()), 0);

    for (int i = 0; i < NV; i++) begin
      prep(VECS[i]);
      pulse_start();
      wait_done();
      @(negedge clk_i);
      chk(result() == VECS[i].exp, "R3/R5/R7/R8", $sformatf("result vec %0d", i),
          int'(result()), int'(VECS[i].exp));
      chk(n_cmds == int'(VECS[i].ncmd), "R4/R6/R8", $sformatf("command count vec %0d", i),
          n_cmds, int'(VECS[i].ncmd));
      chk(fld_bad == 0, "R2", $sformatf("command shape vec %0d", i), fld_bad, 0);
      chk(viol == 0, "R10", $sformatf("request during command vec %0d", i), viol, 0);
      check_order(VECS[i], i);
    end

    // R9 results held while idle
    held = result();
    repeat (20) @(negedge clk_i);
    chk(done_o && result() == held, "R9", "hold after done", int'(result()), int'(held));

    // R9 start clears done at next edge, start during run ignored
    eng_dly = 4;
    prep('{4'd3, 1'b1, 8'h80, 1'b0, 8'd8, 5'b10000, 5'd8});
    @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!done_o && result() == 5'b0, "R9", "cleared by start", int'({done_o, result()}), 0);
    repeat (6) @(negedge clk_i);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!done_o, "R9", "no early done on busy start", int'(done_o), 0);
    wait_done();
    @(negedge clk_i);
    chk(n_cmds == 8, "R9", "command count with busy start", n_cmds, 8);
    chk(result() == 5'b10000, "R9", "result with busy start", int'(result()), 5'b10000);
    chk(viol == 0, "R10", "request during command slow engine", viol, 0);
    repeat (10) @(negedge clk_i);
    chk(n_cmds == 8, "R9", "no restart after busy start", n_cmds, 8);

    finish_all();
  end
endmodule